// File: doc/BRIEF.md
# BERT Receive Status Monitor

This block sits on a serial receive path and checks it against a pseudo-random test pattern. It takes one bit per clock, qualified by a valid strobe. It makes its own reference sequence from the 15-stage polynomial x^15 + x^14 + 1. While it is searching, it loads that reference from the received bits. Once the stream and the reference agree for long enough, it locks and lets the reference run freely. Every bit that disagrees after lock is a bit error.

While locked, the monitor counts received bits and bit errors. At all times it watches for long runs of ones and of zeros. It gathers what it sees into one byte-wide status register. Event bits in that register are cleared when the register is read. Condition bits stay set until the underlying condition has ended and a read has taken place. Each condition also raises a maskable interrupt when it appears and again when it goes away.

A host reads the register by sampling `status_o` and pulsing `rd_i` for one clock. That pulse clears the bits the rules allow.

Top module: `bert_rx_monitor`

## Requirements
- R1: In search, each valid bit is compared with the XOR of the two oldest of the last 15 received bits (all zero after reset). After SYNC_LEN (default 32) consecutive matches, `in_sync_o` goes high, and status bit 0 then reads 1.
- R2: Bit errors are counted in `err_cnt_o` only while `in_sync_o` is high. Each error sets status bit 6, and a read clears that bit.
- R3: `bit_cnt_o` (BIT_CNT_W bits, default 32) counts valid bits while in sync and wraps to zero. The wrap sets status bit 5, which a read clears and only a later wrap sets again.
- R4: `err_cnt_o` (ERR_CNT_W bits, default 24) wraps to zero. The wrap sets status bit 4, which a read clears and only a later wrap sets again.
- R5: Windows of WIN_LEN (64) in-sync bits start at lock. The ERR_LIMIT-th (6th) error within one window drops sync and restarts the search, which sets status bit 1. Reads leave bit 1 set while searching. It clears on the first read after sync is regained.
- R6: RUN_LEN (32) consecutive ones set status bit 3. A read clears it only once a zero has been received.
- R7: RUN_LEN (32) consecutive zeros set status bit 2. A read clears it only once a one has been received.
- R8: Status bit 0 stays set while in sync. A read clears it only when sync is absent.
- R9: All status bits reset to 0. Bit 7 always reads 0.
- R10: `irq_o` is high when any of status bits 6..4 is set with its `irq_mask_i` bit set. It is also high when any of the conditions in-sync, searching, all-zeros or all-ones (mask bits 0..3) has changed in either direction since the last read.
- R11: An event arriving in the same clock as a read leaves its status bit set.
- R12: Cycles with `valid_i` low change no counter and no sync or run state, whatever `bit_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies `bit_i` this cycle |
| bit_i | input | 1 | Received serial bit |
| rd_i | input | 1 | Status read strobe, one cycle |
| irq_mask_i | input | 7 | Per-source interrupt enable (bits 0..3 condition changes, 4..6 events) |
| status_o | output | 8 | Latched status register |
| irq_o | output | 1 | Interrupt request |
| in_sync_o | output | 1 | Real-time lock flag |
| bit_cnt_o | output | BIT_CNT_W | Received-bit count while locked |
| err_cnt_o | output | ERR_CNT_W | Bit-error count |

## Verification
Several rules are checked on every cycle: an event in the clock of a read survives, an in-sync cycle leaves bit 0 set, the loss flag is held while searching, counters hold on idle cycles and reach zero after a wrap, and lock only follows a full run of matches. The exact boundaries can be shown only by the bench's scenarios. These are lock on the 32nd match and not the 31st, five errors in a window tolerated and the sixth fatal, read-clear gated by the end of a condition, the double interrupt around a sync loss, and both counters wrapping under reduced widths.

// File: rtl/bert_mon_pkg.sv
package bert_mon_pkg;
  localparam int unsigned ST_SYNC  = 0;
  localparam int unsigned ST_LOS   = 1;
  localparam int unsigned ST_ZEROS = 2;
  localparam int unsigned ST_ONES  = 3;
  localparam int unsigned ST_ECOVF = 4;
  localparam int unsigned ST_BCOVF = 5;
  localparam int unsigned ST_BERR  = 6;
  localparam int unsigned N_COND   = 4;
  localparam int unsigned N_LATCH  = 7;

  typedef enum logic {SEARCH = 1'b0, LOCKED = 1'b1} sync_state_e;
endpackage

// File: rtl/bert_sync_fsm.sv
module bert_sync_fsm
  import bert_mon_pkg::*;
#(
  parameter int unsigned PRBS_W    = 15,
  parameter int unsigned TAP_A     = 14,
  parameter int unsigned TAP_B     = 13,
  parameter int unsigned SYNC_LEN  = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_LIMIT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic in_sync_o,
  output logic chk_o,
  output logic err_o
);
  localparam int unsigned MW = $clog2(SYNC_LEN + 1);
  localparam int unsigned WW = $clog2(WIN_LEN);
  localparam int unsigned EW = $clog2(ERR_LIMIT + 1);

  sync_state_e       state_q;
  logic [PRBS_W-1:0] lfsr_q;
  logic [MW-1:0]     match_q;
  logic [WW-1:0]     win_q;
  logic [EW-1:0]     werr_q;
  logic              pred, miss;

  assign pred      = lfsr_q[TAP_A] ^ lfsr_q[TAP_B];
  assign miss      = bit_i ^ pred;
  assign in_sync_o = (state_q == LOCKED);
  assign chk_o     = valid_i && in_sync_o;
  assign err_o     = chk_o && miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEARCH;
      lfsr_q  <= '0;
      match_q <= '0;
      win_q   <= '0;
      werr_q  <= '0;
    end else if (valid_i) begin
      unique case (state_q)
        SEARCH: begin
          // self-seed: the reference follows the received stream
          lfsr_q <= {lfsr_q[PRBS_W-2:0], bit_i};
          if (miss) begin
            match_q <= '0;
          end else if (match_q == MW'(SYNC_LEN - 1)) begin
            state_q <= LOCKED;
            match_q <= '0;
            win_q   <= '0;
            werr_q  <= '0;
          end else begin
            match_q <= match_q + 1'b1;
          end
        end
        LOCKED: begin
          lfsr_q <= {lfsr_q[PRBS_W-2:0], pred};
          if (miss && werr_q == EW'(ERR_LIMIT - 1)) begin
            state_q <= SEARCH;
            win_q   <= '0;
            werr_q  <= '0;
          end else if (win_q == WW'(WIN_LEN - 1)) begin
            win_q  <= '0;
            werr_q <= '0;
          end else begin
            win_q  <= win_q + 1'b1;
            werr_q <= werr_q + EW'(miss);
          end
        end
        default: state_q <= SEARCH;
      endcase
    end
  end

  // R1: lock only on a valid bit that completes the match run
  a_r1_lock_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sync_o) |-> ($past(valid_i) && $past(match_q) == MW'(SYNC_LEN - 1)));

  // R5: sync drops only on a detected error
  a_r5_loss_on_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_sync_o) |-> $past(err_o));

  // R12: idle cycles keep the sync state
  a_r12_idle_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(state_q) && $stable(lfsr_q)));
endmodule

// File: rtl/bert_run_det.sv
module bert_run_det #(
  parameter int unsigned RUN_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic bit_i,
  output logic all_ones_o,
  output logic all_zeros_o
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);

  logic [RW-1:0] ones_q, zeros_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= '0;
      zeros_q <= '0;
    end else if (valid_i) begin
      if (bit_i) begin
        zeros_q <= '0;
        if (ones_q != RW'(RUN_LEN)) ones_q <= ones_q + 1'b1;
      end else begin
        ones_q <= '0;
        if (zeros_q != RW'(RUN_LEN)) zeros_q <= zeros_q + 1'b1;
      end
    end
  end

  assign all_ones_o  = (ones_q == RW'(RUN_LEN));
  assign all_zeros_o = (zeros_q == RW'(RUN_LEN));

  // R6 R7: the two run conditions never coexist
  a_r6_runs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(all_ones_o && all_zeros_o));
endmodule

// File: rtl/bert_wrap_cnt.sv
module bert_wrap_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = inc_i && (&cnt_q);

  // R3 R4: overflow pulse lands the count on zero
  a_r3_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_q == '0));

  // R12: no increment, no change
  a_r12_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_q));
endmodule

// File: rtl/bert_status_reg.sv
module bert_status_reg
  import bert_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       in_sync_i,
  input  logic       all_zeros_i,
  input  logic       all_ones_i,
  input  logic       err_ev_i,
  input  logic       ecovf_ev_i,
  input  logic       bcovf_ev_i,
  input  logic [6:0] mask_i,
  output logic [7:0] status_o,
  output logic       irq_o
);
  logic [N_LATCH-1:0] stat_q, set_v, clr_ok;
  logic [N_COND-1:0]  live, prev_q, chg_q;

  assign live = {all_ones_i, all_zeros_i, ~in_sync_i, in_sync_i};

  always_comb begin
    set_v            = '0;
    set_v[ST_SYNC]   = in_sync_i;
    set_v[ST_LOS]    = prev_q[0] & ~in_sync_i;  // search entered
    set_v[ST_ZEROS]  = all_zeros_i;
    set_v[ST_ONES]   = all_ones_i;
    set_v[ST_ECOVF]  = ecovf_ev_i;
    set_v[ST_BCOVF]  = bcovf_ev_i;
    set_v[ST_BERR]   = err_ev_i;
    clr_ok           = '1;
    clr_ok[ST_SYNC]  = ~in_sync_i;
    clr_ok[ST_LOS]   = in_sync_i;
    clr_ok[ST_ZEROS] = ~all_zeros_i;
    clr_ok[ST_ONES]  = ~all_ones_i;
  end

  for (genvar k = 0; k < N_LATCH; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[k] <= 1'b0;
      else         stat_q[k] <= set_v[k] | (stat_q[k] & ~(rd_i & clr_ok[k]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 4'b0010;  // searching out of reset
      chg_q  <= '0;
    end else begin
      prev_q <= live;
      chg_q  <= (live ^ prev_q) | (chg_q & ~{N_COND{rd_i}});
    end
  end

  assign status_o = {1'b0, stat_q};
  assign irq_o    = (|(stat_q[ST_BERR:ST_ECOVF] & mask_i[6:4])) | (|(chg_q & mask_i[3:0]));

  // R11: event in a read cycle is not lost
  a_r11_event_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_ev_i |=> stat_q[ST_BERR]);

  // R8: in-sync bit held while locked
  a_r8_sync_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_sync_i |=> stat_q[ST_SYNC]);

  // R5: loss bit survives reads while searching
  a_r5_los_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[ST_LOS] && !in_sync_i) |=> stat_q[ST_LOS]);

  // R10: any condition edge leaves a pending change
  a_r10_edge_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live != prev_q) |=> (chg_q != '0));
endmodule

// File: rtl/bert_rx_monitor.sv
module bert_rx_monitor #(
  parameter int unsigned BIT_CNT_W = 32,
  parameter int unsigned ERR_CNT_W = 24,
  parameter int unsigned SYNC_LEN  = 32,
  parameter int unsigned RUN_LEN   = 32,
  parameter int unsigned WIN_LEN   = 64,
  parameter int unsigned ERR_LIMIT = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 bit_i,
  input  logic                 rd_i,
  input  logic [6:0]           irq_mask_i,
  output logic [7:0]           status_o,
  output logic                 irq_o,
  output logic                 in_sync_o,
  output logic [BIT_CNT_W-1:0] bit_cnt_o,
  output logic [ERR_CNT_W-1:0] err_cnt_o
);
  logic chk, err, all_ones, all_zeros, bovf, eovf;

  bert_sync_fsm #(
    .PRBS_W(15), .TAP_A(14), .TAP_B(13),
    .SYNC_LEN(SYNC_LEN), .WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT)
  ) u_sync (
    .clk_i, .rst_ni, .valid_i, .bit_i,
    .in_sync_o, .chk_o(chk), .err_o(err)
  );

  bert_run_det #(.RUN_LEN(RUN_LEN)) u_runs (
    .clk_i, .rst_ni, .valid_i, .bit_i,
    .all_ones_o(all_ones), .all_zeros_o(all_zeros)
  );

  bert_wrap_cnt #(.W(BIT_CNT_W)) u_bit_cnt (
    .clk_i, .rst_ni, .inc_i(chk), .cnt_o(bit_cnt_o), .ovf_o(bovf)
  );

  bert_wrap_cnt #(.W(ERR_CNT_W)) u_err_cnt (
    .clk_i, .rst_ni, .inc_i(err), .cnt_o(err_cnt_o), .ovf_o(eovf)
  );

  bert_status_reg u_stat (
    .clk_i, .rst_ni, .rd_i,
    .in_sync_i(in_sync_o), .all_zeros_i(all_zeros), .all_ones_i(all_ones),
    .err_ev_i(err), .ecovf_ev_i(eovf), .bcovf_ev_i(bovf),
    .mask_i(irq_mask_i), .status_o, .irq_o
  );
endmodule

// File: tb/bert_rx_monitor_tb.sv
module bert_rx_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 12;
  localparam int EW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0, bit_i = 1'b0, rd_i = 1'b0;
  logic [6:0]    irq_mask_i = '0;
  logic [7:0]    status_o;
  logic          irq_o, in_sync_o;
  logic [BW-1:0] bit_cnt_o;
  logic [EW-1:0] err_cnt_o;

  int n_chk = 0, n_fail = 0;

  // bench model state
  logic [14:0]   gen = 15'h0001;
  logic [BW-1:0] m_bits;
  logic [EW-1:0] m_errs;
  logic          m_bovf, m_eovf, m_err, m_prev_sync;
  int            m_win_pos, m_win_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  bert_rx_monitor #(.BIT_CNT_W(BW), .ERR_CNT_W(EW)) u_dut (
    .clk_i(clk), .rst_ni, .valid_i, .bit_i, .rd_i, .irq_mask_i,
    .status_o, .irq_o, .in_sync_o, .bit_cnt_o, .err_cnt_o
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bits = '0; m_errs = '0; m_bovf = 0; m_eovf = 0; m_err = 0;
    m_prev_sync = 0; m_win_pos = 0; m_win_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; valid_i = 0; rd_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    model_reset();
  endtask

  // drive one valid bit; ref_b is the true pattern bit
  task automatic send(input logic b, input logic ref_b, input logic rd);
    logic s;
    @(negedge clk);
    s = in_sync_o;
    valid_i = 1; bit_i = b; rd_i = rd;
    if (rd) begin m_bovf = 0; m_eovf = 0; m_err = 0; end
    if (s && !m_prev_sync) begin m_win_pos = 0; m_win_err = 0; end
    if (s) begin
      if (&m_bits) m_bovf = 1;
      m_bits = m_bits + 1'b1;
      if (b != ref_b) begin
        if (&m_errs) m_eovf = 1;
        m_errs = m_errs + 1'b1;
        m_err = 1;
      end
      if ((b != ref_b) && m_win_err == 5) begin
        m_win_pos = 0; m_win_err = 0;
      end else begin
        m_win_err += int'(b != ref_b);
        m_win_pos++;
        if (m_win_pos == 64) begin m_win_pos = 0; m_win_err = 0; end
      end
    end
    m_prev_sync = s;
  endtask

  task automatic send_prbs(input logic flip, input logic rd);
    logic r;
    r = gen[14] ^ gen[13];
    gen = {gen[13:0], r};
    send(r ^ flip, r, rd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 0; rd_i = 0; bit_i = $urandom_range(1, 0);
    end
  endtask

  task automatic do_read();
    @(negedge clk);
    valid_i = 0; rd_i = 1;
    m_bovf = 0; m_eovf = 0; m_err = 0;
    @(negedge clk);
    rd_i = 0;
  endtask

  task automatic align_window();
    while (m_win_pos != 0) send_prbs(0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_sink, inj;
    logic [BW-1:0] bc0;
    seed_sink = $urandom(32'h5eed_0042);
    model_reset();

    // reset state
    do_reset();
    idle(1);
    chk(32'(status_o), 0, "R9 reset status");
    chk(32'(irq_o), 0, "R9 reset irq");
    chk(32'(in_sync_o), 0, "R9 reset in_sync");
    chk(32'(bit_cnt_o), 0, "R9 reset bit count");

    // zeros: lock boundary and all-zeros condition
    for (int i = 0; i < 31; i++) send(0, 0, 0);
    idle(2);
    chk(32'(in_sync_o), 0, "R1 no lock after 31 matches");
    chk(32'(status_o[2]), 0, "R7 no all-zeros after 31");
    send(0, 0, 0);
    idle(2);
    chk(32'(in_sync_o), 1, "R1 lock on 32nd match");
    chk(32'(status_o[0]), 1, "R1 status sync bit");
    chk(32'(status_o[2]), 1, "R7 all-zeros set");
    send(0, 0, 0);
    do_read(); idle(1);
    chk(32'(status_o[2]), 1, "R7 held while zeros continue");
    send(1, 0, 0);
    idle(1);
    chk(32'(status_o[2]), 1, "R7 held until read");
    do_read(); idle(1);
    chk(32'(status_o[2]), 0, "R7 cleared after a one and a read");

    // ones run
    do_reset();
    for (int i = 0; i < 31; i++) send(1, 1, 0);
    idle(2);
    chk(32'(status_o[3]), 0, "R6 no all-ones after 31");
    send(1, 1, 0);
    idle(2);
    chk(32'(status_o[3]), 1, "R6 all-ones set");
    send(1, 1, 0);
    do_read(); idle(1);
    chk(32'(status_o[3]), 1, "R6 held while ones continue");
    send(0, 0, 0);
    do_read(); idle(1);
    chk(32'(status_o[3]), 0, "R6 cleared after a zero and a read");

    // pattern lock, masking, read
    do_reset();
    irq_mask_i = '0;
    for (int i = 0; i < 50; i++) send_prbs(0, 0);
    idle(2);
    chk(32'(in_sync_o), 1, "R1 lock on pattern");
    chk(32'(status_o[1]), 0, "R5 no loss yet");
    chk(32'(irq_o), 0, "R10 masked irq low");
    irq_mask_i = 7'h7F;
    idle(1);
    chk(32'(irq_o), 1, "R10 unmasked sync change");
    do_read(); idle(1);
    chk(32'(status_o[0]), 1, "R8 sync bit kept by read while locked");
    chk(32'(irq_o), 0, "R10 irq cleared by read");

    // idle cycles change nothing
    bc0 = bit_cnt_o;
    idle(8);
    chk(32'(bit_cnt_o), 32'(bc0), "R12 bit count held on idle");
    chk(32'(in_sync_o), 1, "R12 sync held on idle");

    // clean traffic
    for (int i = 0; i < 100; i++) send_prbs(0, 0);
    idle(2);
    chk(32'(bit_cnt_o), 32'(m_bits), "R3 bit count");
    chk(32'(err_cnt_o), 0, "R2 no errors on clean pattern");

    // error with simultaneous read
    send_prbs(1, 1);
    idle(2);
    chk(32'(status_o[6]), 1, "R11 event kept over same-cycle read");
    chk(32'(err_cnt_o), 32'(m_errs), "R2 error counted");
    do_read(); idle(1);
    chk(32'(status_o[6]), 0, "R2 error bit cleared by read");

    // random sparse errors; wrap the error counter
    inj = 0;
    for (int i = 0; i < 4000 && inj < 20; i++) begin
      logic f;
      f = ($urandom_range(15, 0) == 0) && (m_win_err < 4);
      if (f) inj++;
      send_prbs(f, 0);
    end
    idle(2);
    chk(32'(in_sync_o), 1, "R5 sparse errors keep lock");
    chk(32'(err_cnt_o), 32'(m_errs), "R4 error count");
    chk(32'(status_o[4]), 32'(m_eovf), "R4 error counter wrap flag");
    chk(32'(status_o[6]), 32'(m_err), "R2 error flag");
    chk(32'(status_o[5]), 32'(m_bovf), "R3 bit wrap flag before wrap");
    do_read(); idle(1);
    chk(32'(status_o[4]), 0, "R4 wrap flag cleared by read");

    // wrap the bit counter
    for (int i = 0; i < 5000 && !m_bovf; i++) send_prbs(0, 0);
    idle(2);
    chk(32'(status_o[5]), 1, "R3 bit counter wrap flag");
    chk(32'(bit_cnt_o), 32'(m_bits), "R3 bit count after wrap");
    do_read(); idle(1);
    chk(32'(status_o[5]), 0, "R3 wrap flag cleared by read");
    idle(3);
    chk(32'(status_o[5]), 0, "R3 not set again without wrap");

    // error window: five tolerated, sixth drops sync
    align_window();
    for (int i = 0; i < 5; i++) begin
      send_prbs(1, 0);
      repeat (3) send_prbs(0, 0);
    end
    align_window();
    idle(2);
    chk(32'(in_sync_o), 1, "R5 five errors in a window tolerated");
    do_read(); idle(1);
    for (int i = 0; i < 6; i++) send_prbs(1, 0);
    idle(2);
    chk(32'(in_sync_o), 0, "R5 sixth error drops sync");
    chk(32'(status_o[1]), 1, "R5 loss bit set");
    chk(32'(irq_o), 1, "R10 irq on sync loss");
    do_read(); idle(1);
    chk(32'(status_o[1]), 1, "R5 loss bit held while searching");
    chk(32'(status_o[0]), 0, "R8 sync bit cleared by read when unlocked");
    chk(32'(irq_o), 0, "R10 irq cleared by read");
    for (int i = 0; i < 50; i++) send_prbs(0, 0);
    idle(2);
    chk(32'(in_sync_o), 1, "R1 relock");
    chk(32'(status_o[1]), 1, "R5 loss bit held after relock");
    chk(32'(irq_o), 1, "R10 irq on sync regained");
    do_read(); idle(1);
    chk(32'(status_o[1]), 0, "R5 loss bit cleared after relock read");
    chk(32'(status_o[7]), 0, "R9 bit 7 reads zero");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule